// File: doc/BRIEF.md
# DRAM Strobe Sequencer with Refresh and Wake-Up

This block sits between a synchronous requester and a 64K x 4 asynchronous DRAM with a multiplexed address bus. A requester offers one word access at a time through a valid/ready handshake: a 16-bit word address, a write flag and a 4-bit write value. The block turns each access into a row strobe, a column strobe, a write strobe and an output-enable strobe. It drives the row and column halves of the address in turn on an 8-line bus, and controls the drive enable of the data lines. Read data returns with a one-cycle valid pulse.

The block handles the DRAM's own upkeep. After reset it waits for a power-up pause and then runs eight dummy row-only cycles. It runs those eight cycles again whenever the row strobe has stayed high for too long. A free-running interval timer raises a refresh request, and the block serves it with a row-only cycle that drives an internal 8-bit row counter. Every delay is a parameter counted in clock cycles. The defaults suit a 50 MHz clock: 500 µs pause, 2 ms inactivity limit, 15.6 µs refresh interval, and strobe widths of 6 (row low), 5 (precharge), 2 (row-to-column) and 3 (column low) cycles.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is asserted, all four strobes are high, the data drive enable is low, and both ready and read-valid are low.
- R2: After reset the row strobe stays high for INIT_PAUSE_CYC cycles. The block then issues exactly WAKE_CYCLES row-only cycles before ready is first raised.
- R3: When the row strobe has been high for IDLE_LIMIT_CYC consecutive cycles outside the pause, WAKE_CYCLES row-only cycles are issued again before the next host access.
- R4: Every REF_INTERVAL_CYC cycles a refresh becomes pending. A pending refresh is served before any waiting host request, but it never cuts into a host cycle already started. It is a row-only cycle: the column strobe stays high and the address carries an 8-bit row counter. The counter starts at 0 and advances by one after every row-only cycle, dummy cycles included.
- R5: During a host access the address bus carries request address bits [15:8] from the fall of the row strobe until the column strobe falls. It carries bits [7:0] while the column strobe is low, and it is 0 whenever the row strobe is high.
- R6: In a host access the row strobe falls in the cycle after acceptance. The column strobe falls T_RCD_CYC cycles later and stays low for max(T_CAS_CYC, T_RAS_CYC - T_RCD_CYC) cycles. Both strobes then rise together. In a row-only cycle the row strobe is low for T_RAS_CYC cycles. After either kind of cycle the row strobe stays high for T_RP_CYC cycles, plus at least one idle cycle before the next fall.
- R7: In a read, the output enable is low for the whole row-low period. The data lines are sampled on the edge that ends the last column-low cycle. In the next cycle read-valid is high for exactly one cycle, and read data holds the value last written to that address.
- R8: In a write, the write strobe is low and the data drive enable is high from the fall of the row strobe until the column strobe rises, so the write strobe is already low when the column strobe falls. The data lines carry the write value during that time, and the output enable stays high.
- R9: Ready is high only when no cycle is in progress, the pause is over, and no wake-up or refresh is pending. An access is accepted on a cycle where valid and ready are both high, and ready is low in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Access can be accepted |
| req_addr_i | input | 16 | Word address, row in [15:8], column in [7:0] |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 4 | Write value |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | 4 | Read value |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | 8 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Data driven toward the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for the data lines |
| dram_dq_i | input | 4 | Data returned from the DRAM |

## Verification
Acceptance happens on the edge where valid and ready are both high. The row strobe falls in the next cycle, the column strobe T_RCD_CYC cycles after that, and read-valid one cycle after the last column-low cycle. A row-only cycle starts one idle cycle after the previous precharge ends. The bench keeps a behavioural model that advances on every rising edge using those offsets. It compares every strobe, the address, the drive enable, ready and read-valid on the falling edge that follows, so each output is checked in the cycle where the model says it is due. Read data is compared against a scoreboard of past writes in the cycle where read-valid is expected.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_RONLY,
    S_RCD,
    S_CAS,
    S_PRE
  } seq_state_e;
endpackage

// File: rtl/dram_refresh_tmr.sv
module dram_refresh_tmr #(
  parameter int REF_INTERVAL_CYC = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_taken_i,
  output logic ref_pend_o
);
  localparam int CW = $clog2(REF_INTERVAL_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(REF_INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      ref_pend_o <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      // a new tick outranks the clear so no interval is lost
      if (tick)             ref_pend_o <= 1'b1;
      else if (ref_taken_i) ref_pend_o <= 1'b0;
    end
  end

  // R4
  ref_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ref_pend_o);
endmodule

// File: rtl/dram_wake_tmr.sv
module dram_wake_tmr #(
  parameter int IDLE_LIMIT_CYC = 100000,
  parameter int WAKE_CYCLES    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ras_low_i,
  input  logic dummy_taken_i,
  output logic wake_pend_o
);
  localparam int IW = $clog2(IDLE_LIMIT_CYC + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic [IW-1:0] idle_q;
  logic [WW-1:0] wake_q;
  logic          idle_hit;

  assign idle_hit = !hold_i && !ras_low_i && (idle_q == IW'(IDLE_LIMIT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      wake_q <= WW'(WAKE_CYCLES);
    end else begin
      if (hold_i || ras_low_i || idle_hit) idle_q <= '0;
      else                                 idle_q <= idle_q + 1'b1;
      if (idle_hit)           wake_q <= WW'(WAKE_CYCLES);
      else if (dummy_taken_i) wake_q <= wake_q - 1'b1;
    end
  end

  assign wake_pend_o = (wake_q != '0);

  // R3
  rewake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_hit |=> wake_pend_o);
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W          = 8,
  parameter int DATA_W         = 4,
  parameter int INIT_PAUSE_CYC = 25000,
  parameter int T_RAS_CYC      = 6,
  parameter int T_RP_CYC       = 5,
  parameter int T_RCD_CYC      = 2,
  parameter int T_CAS_CYC      = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [2*ROW_W-1:0]  req_addr_i,
  input  logic                req_we_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  input  logic                wake_pend_i,
  input  logic                ref_pend_i,
  output logic                dummy_taken_o,
  output logic                ref_taken_o,
  output logic                in_pause_o,
  output logic                ras_low_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic                oe_n_o,
  output logic [ROW_W-1:0]    addr_o,
  output logic [DATA_W-1:0]   dq_o,
  output logic                dq_oe_o,
  input  logic [DATA_W-1:0]   dq_i
);
  localparam int ADDR_W  = 2 * ROW_W;
  // column phase stretched so the row-low time is met
  localparam int CAS_LEN = (T_CAS_CYC > T_RAS_CYC - T_RCD_CYC) ? T_CAS_CYC
                                                               : T_RAS_CYC - T_RCD_CYC;
  localparam int CNT_W   = $clog2(INIT_PAUSE_CYC + T_RAS_CYC + T_RP_CYC
                                  + T_RCD_CYC + CAS_LEN + 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, lim;
  logic              last, idle, accept, start_ronly, host_act;
  logic [ROW_W-1:0]  row_q, col_q, ref_row_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  assign idle          = (state_q == S_IDLE);
  assign dummy_taken_o = idle && wake_pend_i;
  assign ref_taken_o   = idle && !wake_pend_i && ref_pend_i;
  assign start_ronly   = dummy_taken_o || ref_taken_o;
  assign req_ready_o   = idle && !wake_pend_i && !ref_pend_i;
  assign accept        = req_ready_o && req_valid_i;

  always_comb begin
    case (state_q)
      S_PAUSE: lim = CNT_W'(INIT_PAUSE_CYC - 1);
      S_RONLY: lim = CNT_W'(T_RAS_CYC - 1);
      S_RCD:   lim = CNT_W'(T_RCD_CYC - 1);
      S_CAS:   lim = CNT_W'(CAS_LEN - 1);
      S_PRE:   lim = CNT_W'(T_RP_CYC - 1);
      default: lim = '0;
    endcase
  end
  assign last = (cnt_q == lim);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_PAUSE: if (last) state_d = S_IDLE;
      S_IDLE: begin
        if (start_ronly) state_d = S_RONLY;
        else if (accept) state_d = S_RCD;
      end
      S_RONLY: if (last) state_d = S_PRE;
      S_RCD:   if (last) state_d = S_CAS;
      S_CAS:   if (last) state_d = S_PRE;
      S_PRE:   if (last) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_PAUSE;
      cnt_q       <= '0;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      ref_row_q   <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q || state_q == S_IDLE) ? '0 : cnt_q + 1'b1;
      if (accept) begin
        row_q   <= req_addr_i[ADDR_W-1:ROW_W];
        col_q   <= req_addr_i[ROW_W-1:0];
        wr_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == S_RONLY && last) ref_row_q <= ref_row_q + 1'b1;
      rsp_valid_o <= (state_q == S_CAS) && last && !wr_q;
      if ((state_q == S_CAS) && last && !wr_q) rsp_rdata_o <= dq_i;
    end
  end

  assign in_pause_o = (state_q == S_PAUSE);
  assign ras_low_o  = (state_q == S_RONLY) || (state_q == S_RCD) || (state_q == S_CAS);
  assign host_act   = (state_q == S_RCD) || (state_q == S_CAS);
  assign ras_n_o    = !ras_low_o;
  assign cas_n_o    = !(state_q == S_CAS);
  assign we_n_o     = !(host_act && wr_q);
  assign oe_n_o     = !(host_act && !wr_q);
  assign dq_oe_o    = host_act && wr_q;
  assign dq_o       = wdata_q;

  always_comb begin
    case (state_q)
      S_RONLY: addr_o = ref_row_q;
      S_RCD:   addr_o = row_q;
      S_CAS:   addr_o = col_q;
      default: addr_o = '0;
    endcase
  end

  // R6
  cas_after_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> !$past(ras_n_o));
  // R8
  early_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !we_n_o) |-> !$past(we_n_o));
  // R9
  single_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R7
  rsp_after_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (!$past(cas_n_o) && cas_n_o));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W            = 8,
  parameter int DATA_W           = 4,
  parameter int INIT_PAUSE_CYC   = 25000,
  parameter int WAKE_CYCLES      = 8,
  parameter int IDLE_LIMIT_CYC   = 100000,
  parameter int REF_INTERVAL_CYC = 780,
  parameter int T_RAS_CYC        = 6,
  parameter int T_RP_CYC         = 5,
  parameter int T_RCD_CYC        = 2,
  parameter int T_CAS_CYC        = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [2*ROW_W-1:0]  req_addr_i,
  input  logic                req_we_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                dram_ras_n_o,
  output logic                dram_cas_n_o,
  output logic                dram_we_n_o,
  output logic                dram_oe_n_o,
  output logic [ROW_W-1:0]    dram_addr_o,
  output logic [DATA_W-1:0]   dram_dq_o,
  output logic                dram_dq_oe_o,
  input  logic [DATA_W-1:0]   dram_dq_i
);
  logic ref_pend, ref_taken, wake_pend, dummy_taken, in_pause, ras_low;

  dram_refresh_tmr #(
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC)
  ) i_refresh_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_taken_i (ref_taken),
    .ref_pend_o  (ref_pend)
  );

  dram_wake_tmr #(
    .IDLE_LIMIT_CYC(IDLE_LIMIT_CYC),
    .WAKE_CYCLES   (WAKE_CYCLES)
  ) i_wake_tmr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hold_i        (in_pause),
    .ras_low_i     (ras_low),
    .dummy_taken_i (dummy_taken),
    .wake_pend_o   (wake_pend)
  );

  dram_seq #(
    .ROW_W         (ROW_W),
    .DATA_W        (DATA_W),
    .INIT_PAUSE_CYC(INIT_PAUSE_CYC),
    .T_RAS_CYC     (T_RAS_CYC),
    .T_RP_CYC      (T_RP_CYC),
    .T_RCD_CYC     (T_RCD_CYC),
    .T_CAS_CYC     (T_CAS_CYC)
  ) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_addr_i    (req_addr_i),
    .req_we_i      (req_we_i),
    .req_wdata_i   (req_wdata_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .wake_pend_i   (wake_pend),
    .ref_pend_i    (ref_pend),
    .dummy_taken_o (dummy_taken),
    .ref_taken_o   (ref_taken),
    .in_pause_o    (in_pause),
    .ras_low_o     (ras_low),
    .ras_n_o       (dram_ras_n_o),
    .cas_n_o       (dram_cas_n_o),
    .we_n_o        (dram_we_n_o),
    .oe_n_o        (dram_oe_n_o),
    .addr_o        (dram_addr_o),
    .dq_o          (dram_dq_o),
    .dq_oe_o       (dram_dq_oe_o),
    .dq_i          (dram_dq_i)
  );
endmodule

// File: tb/test_dram_ctrl.sv
module test_dram_ctrl;
  localparam int P_INIT = 30;
  localparam int P_WAKE = 8;
  localparam int P_IDLE = 120;
  localparam int P_REF  = 300;
  localparam int P_RAS  = 6;
  localparam int P_RP   = 5;
  localparam int P_RCD  = 2;
  localparam int P_CAS  = 3;
  localparam int P_CL   = (P_CAS > P_RAS - P_RCD) ? P_CAS : P_RAS - P_RCD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [3:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0]  dram_addr;
  logic [3:0]  dram_dq_o, dram_dq_i;

  always #2.5 clk = ~clk;

  dram_ctrl #(
    .INIT_PAUSE_CYC  (P_INIT),
    .WAKE_CYCLES     (P_WAKE),
    .IDLE_LIMIT_CYC  (P_IDLE),
    .REF_INTERVAL_CYC(P_REF),
    .T_RAS_CYC       (P_RAS),
    .T_RP_CYC        (P_RP),
    .T_RCD_CYC       (P_RCD),
    .T_CAS_CYC       (P_CAS)
  ) i_dram_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_addr_i   (req_addr),
    .req_we_i     (req_we),
    .req_wdata_i  (req_wdata),
    .rsp_valid_o  (rsp_valid),
    .rsp_rdata_o  (rsp_rdata),
    .dram_ras_n_o (dram_ras_n),
    .dram_cas_n_o (dram_cas_n),
    .dram_we_n_o  (dram_we_n),
    .dram_oe_n_o  (dram_oe_n),
    .dram_addr_o  (dram_addr),
    .dram_dq_o    (dram_dq_o),
    .dram_dq_oe_o (dram_dq_oe),
    .dram_dq_i    (dram_dq_i)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // small DRAM stand-in keyed by row[3:0], col[3:0]
  logic [3:0] mem [256];
  logic [7:0] stub_row = '0;
  logic       stub_prev_ras = 1'b1;
  initial for (int i = 0; i < 256; i++) mem[i] = '0;
  assign dram_dq_i = (!dram_cas_n && !dram_oe_n) ? mem[{stub_row[3:0], dram_addr[3:0]}] : '0;
  always @(negedge clk) begin
    if (stub_prev_ras && !dram_ras_n) stub_row = dram_addr;
    if (!dram_cas_n && !dram_we_n) mem[{stub_row[3:0], dram_addr[3:0]}] = dram_dq_o;
    stub_prev_ras = dram_ras_n;
  end

  // behavioural reference: op 0 none, 1 wake dummy, 2 refresh, 3 read, 4 write
  logic [3:0] sb [256];
  initial for (int i = 0; i < 256; i++) sb[i] = '0;
  int m_pause, m_wake, m_wake_src, m_refc, m_idle, m_row, m_row_used;
  int m_op, m_pos, m_op_src, m_ref_over_req, m_rewakes;
  bit m_pend;
  logic [15:0] m_addr;
  logic [3:0]  m_wd, m_exp_rd;

  function automatic bit m_ras_low();
    if (m_op == 1 || m_op == 2) return m_pos < P_RAS;
    if (m_op == 3 || m_op == 4) return m_pos < P_RCD + P_CL;
    return 1'b0;
  endfunction

  function automatic int m_len(input int op);
    return (op <= 2) ? P_RAS + P_RP : P_RCD + P_CL + P_RP;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pause = P_INIT; m_wake = P_WAKE; m_wake_src = 2; m_pend = 1'b0;
      m_refc = 0; m_idle = 0; m_row = 0; m_row_used = 0; m_op = 0; m_pos = 0;
      m_op_src = 2; m_ref_over_req = 0; m_rewakes = 0;
    end else begin
      bit was_pause, was_ras_low;
      was_pause   = (m_pause > 0);
      was_ras_low = m_ras_low();
      if (m_pause > 0) m_pause--;
      else if (m_op != 0) begin
        m_pos++;
        if (m_pos == m_len(m_op)) m_op = 0;
      end else if (m_wake > 0) begin
        m_op = 1; m_pos = 0; m_wake--; m_op_src = m_wake_src;
        m_row_used = m_row; m_row = (m_row + 1) % 256;
      end else if (m_pend) begin
        m_op = 2; m_pos = 0; m_pend = 1'b0;
        m_row_used = m_row; m_row = (m_row + 1) % 256;
        if (req_valid) m_ref_over_req++;
      end else if (req_valid) begin
        m_op = req_we ? 4 : 3; m_pos = 0; m_addr = req_addr; m_wd = req_wdata;
        if (req_we) sb[{req_addr[11:8], req_addr[3:0]}] = req_wdata;
        else m_exp_rd = sb[{req_addr[11:8], req_addr[3:0]}];
      end
      if (m_refc == P_REF - 1) begin m_refc = 0; m_pend = 1'b1; end
      else m_refc++;
      if (was_pause || was_ras_low) m_idle = 0;
      else if (m_idle + 1 == P_IDLE) begin
        m_idle = 0; m_wake = P_WAKE; m_wake_src = 3; m_rewakes++;
      end else m_idle++;
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string t_str, t_adr;
      bit    host_lo, cas_lo, e_rv, e_rdy;
      int    e_addr;
      host_lo = (m_op == 3 || m_op == 4) && m_pos < P_RCD + P_CL;
      cas_lo  = host_lo && m_pos >= P_RCD;
      if (m_pause > 0) t_str = "R2";
      else if (m_op == 1) t_str = (m_op_src == 3) ? "R3" : "R2";
      else if (m_op == 2) t_str = "R4";
      else t_str = "R6";
      t_adr = (m_op == 1 || m_op == 2) ? t_str : "R5";
      e_addr = 0;
      if ((m_op == 1 || m_op == 2) && m_pos < P_RAS) e_addr = m_row_used;
      else if (host_lo && !cas_lo) e_addr = int'(m_addr[15:8]);
      else if (cas_lo) e_addr = int'(m_addr[7:0]);
      e_rv  = (m_op == 3) && (m_pos == P_RCD + P_CL);
      e_rdy = (m_pause == 0) && (m_op == 0) && (m_wake == 0) && !m_pend;
      chk(t_str, "ras_n", 32'(dram_ras_n), 32'(!m_ras_low()));
      chk(t_str, "cas_n", 32'(dram_cas_n), 32'(!cas_lo));
      chk(t_adr, "addr", 32'(dram_addr), 32'(e_addr));
      chk("R8", "we_n", 32'(dram_we_n), 32'(!(m_op == 4 && host_lo)));
      chk("R8", "dq_oe", 32'(dram_dq_oe), 32'(m_op == 4 && host_lo));
      if (m_op == 4 && host_lo) chk("R8", "dq_o", 32'(dram_dq_o), 32'(m_wd));
      chk("R7", "oe_n", 32'(dram_oe_n), 32'(!(m_op == 3 && host_lo)));
      chk("R7", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (e_rv) chk("R7", "rsp_rdata", 32'(rsp_rdata), 32'(m_exp_rd));
      chk("R9", "ready", 32'(req_ready), 32'(e_rdy));
    end
  end

  // edge monitor for row strobe falls
  int cyc = 0, falls = 0, first_fall = -1;
  bit prev_ras = 1'b1;
  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_ras && !dram_ras_n) begin
        falls++;
        if (first_fall < 0) first_fall = cyc;
      end
      prev_ras = dram_ras_n;
    end
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected<=%0d", wd, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_req(input logic [15:0] a, input logic we, input logic [3:0] d);
    req_addr = a; req_we = we; req_wdata = d; req_valid = 1'b1;
    while (!(m_op == 3 || m_op == 4)) @(negedge clk);
    req_valid = 1'b0;
    while (m_op != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ras_n", 32'(dram_ras_n), 32'(1));
    chk("R1", "cas_n", 32'(dram_cas_n), 32'(1));
    chk("R1", "we_n", 32'(dram_we_n), 32'(1));
    chk("R1", "oe_n", 32'(dram_oe_n), 32'(1));
    chk("R1", "dq_oe", 32'(dram_dq_oe), 32'(0));
    chk("R1", "ready", 32'(req_ready), 32'(0));
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'(0));
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);
    // R2 pause then exactly the wake cycles
    chk("R2", "falls_before_ready", 32'(falls), 32'(P_WAKE));
    chk("R2", "pause_respected", 32'(first_fall >= P_INIT), 32'(1));
    // R8 / R7 distinct patterns
    do_req(16'h0102, 1'b1, 4'h5);
    do_req(16'h1A0F, 1'b1, 4'hA);
    do_req(16'hF3C4, 1'b1, 4'h3);
    do_req(16'h0000, 1'b1, 4'hF);
    do_req(16'hFFFF, 1'b1, 4'h6);
    do_req(16'h0102, 1'b0, 4'h0);
    do_req(16'h1A0F, 1'b0, 4'h0);
    do_req(16'hF3C4, 1'b0, 4'h0);
    do_req(16'h0000, 1'b0, 4'h0);
    do_req(16'hFFFF, 1'b0, 4'h0);
    // back-to-back traffic across several refresh intervals (R4)
    for (int i = 0; i < 32; i++) begin
      do_req(16'(i * 16'h0111), 1'b1, 4'(i ^ 5));
      do_req(16'(i * 16'h0111), 1'b0, 4'h0);
    end
    chk("R4", "refresh_won_over_request", 32'(m_ref_over_req > 0), 32'(1));
    // long quiet period forces a repeat of the wake cycles (R3)
    begin
      int f0;
      f0 = falls;
      repeat (400) @(negedge clk);
      chk("R3", "rewake_falls", 32'(falls - f0 >= P_WAKE), 32'(1));
      chk("R3", "rewake_seen", 32'(m_rewakes > 0), 32'(1));
    end
    do_req(16'h0102, 1'b0, 4'h0);
    do_req(16'h2233, 1'b1, 4'h9);
    do_req(16'h2233, 1'b0, 4'h0);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule